// File: doc/BRIEF.md
# Redundant Reference Clock Supervisor

This block watches two redundant reference clocks and chooses one of them as the active reference. Both references are sampled all the time by a faster free-running system clock, whichever one is in use. If a reference stops toggling and stays at one level for longer than its expected period plus a margin, the block raises a fault flag for that reference and holds the flag until software-side alarm handling clears it.

When the reference in use fails, the block moves to the other reference, but only if that one is still healthy. If both have failed, the choice is frozen and a both-failed alarm is raised. A manual-override input hands the choice entirely to the primary-select pin and disables automatic failover. The block also produces a gated copy of the chosen reference, re-timed to the system clock. This copy changes source only while it is low, so a switch never creates a shortened pulse.

Top module: `clk_failover`

## Requirements
- R1: While `rst` is high, `bad_a`, `bad_b`, `both_bad` and `clk_out` are 0 and `cur_sel` equals `prim_sel` (0 = reference A, 1 = reference B).
- R2: A reference with no edge for `PERIOD_CYC + MARGIN_CYC` system cycles gets its flag set, whether or not it is selected. A reference that keeps toggling with half periods well under that limit is never flagged.
- R3: A set flag stays set, even after its reference recovers, until `alarm_clr` is high while the reference is toggling.
- R4: With `man_ovr` low, if the selected reference is flagged and the other is not, `cur_sel` moves to the other reference on the next cycle.
- R5: With `man_ovr` high, `cur_sel` follows `prim_sel` on the next cycle, even onto a flagged reference, and no automatic failover takes place.
- R6: While both flags are set, `both_bad` is 1 and, with `man_ovr` low, `cur_sel` does not change.
- R7: `clk_out` changes source only in a cycle where it is low, and it never shows a high pulse shorter than the high phase of a healthy reference.
- R8: Clearing the flags with `alarm_clr` never moves `cur_sel` back to the primary by itself.
- R9: With `man_ovr` low, a change of `prim_sel` moves `cur_sel` to the newly named reference, provided that reference is not flagged.
- R10: `clk_out` repeats the selected reference at the reference's own rate, with one rising edge per reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system sampling clock |
| rst | input | 1 | Synchronous active-high master reset |
| ref_a | input | 1 | Reference clock A (asynchronous) |
| ref_b | input | 1 | Reference clock B (asynchronous) |
| prim_sel | input | 1 | Primary choice: 0 = A, 1 = B |
| man_ovr | input | 1 | Manual override: selection follows prim_sel only |
| alarm_clr | input | 1 | Clears latched fault flags |
| cur_sel | output | 1 | Reference in use: 0 = A, 1 = B |
| bad_a | output | 1 | Latched fault flag of reference A |
| bad_b | output | 1 | Latched fault flag of reference B |
| both_bad | output | 1 | Both references flagged |
| clk_out | output | 1 | Gated, re-timed copy of the selected reference |

## Verification
The properties assume the references are either toggling with half periods of several system cycles or fully stopped, and that `prim_sel`, `man_ovr` and `alarm_clr` are steady for many cycles at a time. The stimulus keeps to this. The bench changes controls only at falling system-clock edges. It produces its references with fixed half periods of 4 and 5 system cycles, and it stops them by freezing their level. When both references fail, the bench restores both before it pulses the clear, so that no partial recovery can start a failover that depends on timing.

// File: rtl/cfo_pkg.sv
package cfo_pkg;

    // Output gating phases
    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,   // passing the current source
        GS_DRAIN = 2'd1,   // waiting for the old source to go low
        GS_WAIT  = 2'd2    // output parked low until new source falls
    } gate_state_t;

    // Per-reference monitor result in the system domain
    typedef struct packed {
        logic lvl;    // synchronised level
        logic fall;   // falling edge seen this cycle
        logic fault;  // no edge for the limit window
    } mon_t;

    function automatic logic pick(input logic [1:0] v, input logic idx);
        return idx ? v[1] : v[0];
    endfunction

endpackage

// File: rtl/cfo_edge_mon.sv
module cfo_edge_mon
    import cfo_pkg::*;
#(
    parameter int PERIOD_CYC = 10,
    parameter int MARGIN_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output mon_t mon
);
    localparam int LIMIT = PERIOD_CYC + MARGIN_CYC;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    // [0],[1] synchroniser, [2] previous synchronised level
    logic [2:0]    sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else begin
            sh <= {sh[1:0], ref_in};
            if (sh[1] != sh[2])
                cnt <= '0;
            else if (cnt != LIM_V)
                cnt <= cnt + 1'b1;
        end
    end

    assign mon = '{lvl: sh[1], fall: sh[2] & ~sh[1], fault: (cnt == LIM_V)};

endmodule

// File: rtl/cfo_select.sv
module cfo_select
    import cfo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       prim_sel,
    input  logic       man_ovr,
    input  logic       alarm_clr,
    input  logic [1:0] fault,
    output logic       cur_sel,
    output logic [1:0] bad
);
    logic       prim_q;
    logic       sel_nx;
    logic [1:0] bad_nx;

    always_comb begin
        // a live fault wins over a clear in the same cycle
        bad_nx = fault | (bad & {2{~alarm_clr}});
        sel_nx = cur_sel;
        if (man_ovr)
            sel_nx = prim_sel;
        else if (pick(bad, cur_sel) && !pick(bad, ~cur_sel))
            sel_nx = ~cur_sel;
        else if ((prim_sel != prim_q) && !pick(bad, prim_sel))
            sel_nx = prim_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q  <= prim_sel;
            cur_sel <= prim_sel;
            bad     <= '0;
        end else begin
            prim_q  <= prim_sel;
            cur_sel <= sel_nx;
            bad     <= bad_nx;
        end
    end

endmodule

// File: rtl/cfo_gate.sv
module cfo_gate
    import cfo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic [1:0] lvl,
    input  logic [1:0] fall,
    input  logic [1:0] bad,
    output logic       clk_out,
    output logic       src
);
    gate_state_t st, st_nx;
    logic        src_nx;
    logic        out_nx;

    always_comb begin
        st_nx  = st;
        src_nx = src;
        out_nx = 1'b0;
        unique case (st)
            GS_RUN: begin
                out_nx = pick(lvl, src);
                if (sel != src)
                    st_nx = GS_DRAIN;
            end
            GS_DRAIN: begin
                if (sel == src) begin
                    st_nx  = GS_RUN;
                    out_nx = pick(lvl, src);
                end else if (!pick(lvl, src) || pick(bad, src)) begin
                    st_nx  = GS_WAIT;
                    src_nx = sel;
                end else begin
                    out_nx = pick(lvl, src);
                end
            end
            GS_WAIT: begin
                if (sel != src)
                    src_nx = sel;
                else if (pick(fall, src))
                    st_nx = GS_RUN;
            end
            default: st_nx = GS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= GS_RUN;
            src     <= sel;
            clk_out <= 1'b0;
        end else begin
            st      <= st_nx;
            src     <= src_nx;
            clk_out <= out_nx;
        end
    end

endmodule

// File: rtl/clk_failover.sv
module clk_failover
    import cfo_pkg::*;
#(
    parameter int PERIOD_CYC = 10,
    parameter int MARGIN_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_a,
    input  logic ref_b,
    input  logic prim_sel,
    input  logic man_ovr,
    input  logic alarm_clr,
    output logic cur_sel,
    output logic bad_a,
    output logic bad_b,
    output logic both_bad,
    output logic clk_out
);
    localparam int N_REF = 2;

    logic [N_REF-1:0] refs;
    logic [N_REF-1:0] lvl, fall, fault, bad;
    logic             drv_src;
    mon_t             mons [N_REF];

    assign refs = {ref_b, ref_a};

    for (genvar gi = 0; gi < N_REF; gi++) begin : g_mon
        cfo_edge_mon #(
            .PERIOD_CYC(PERIOD_CYC),
            .MARGIN_CYC(MARGIN_CYC)
        ) u_mon (
            .clk   (clk),
            .rst   (rst),
            .ref_in(refs[gi]),
            .mon   (mons[gi])
        );
    end

    always_comb begin
        for (int i = 0; i < N_REF; i++) begin
            lvl[i]   = mons[i].lvl;
            fall[i]  = mons[i].fall;
            fault[i] = mons[i].fault;
        end
    end

    cfo_select u_sel (
        .clk      (clk),
        .rst      (rst),
        .prim_sel (prim_sel),
        .man_ovr  (man_ovr),
        .alarm_clr(alarm_clr),
        .fault    (fault),
        .cur_sel  (cur_sel),
        .bad      (bad)
    );

    cfo_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .sel    (cur_sel),
        .lvl    (lvl),
        .fall   (fall),
        .bad    (bad),
        .clk_out(clk_out),
        .src    (drv_src)
    );

    assign bad_a    = bad[0];
    assign bad_b    = bad[1];
    assign both_bad = &bad;

endmodule

// File: rtl/clk_failover_chk.sv
module clk_failover_chk (
    input logic       clk,
    input logic       rst,
    input logic       prim_sel,
    input logic       man_ovr,
    input logic       alarm_clr,
    input logic [1:0] bad,
    input logic       cur_sel,
    input logic       clk_out,
    input logic       drv_src
);
    p_flag_sticky_a_r3: assert property (@(posedge clk) disable iff (rst)
        (bad[0] && !alarm_clr) |=> bad[0]);

    p_flag_sticky_b_r3: assert property (@(posedge clk) disable iff (rst)
        (bad[1] && !alarm_clr) |=> bad[1]);

    p_auto_failover_r4: assert property (@(posedge clk) disable iff (rst)
        (!man_ovr && (cur_sel ? (bad[1] && !bad[0]) : (bad[0] && !bad[1])))
        |=> (cur_sel != $past(cur_sel)));

    p_override_follow_r5: assert property (@(posedge clk) disable iff (rst)
        man_ovr |=> (cur_sel == $past(prim_sel)));

    p_both_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (bad == 2'b11 && !man_ovr) |=> $stable(cur_sel));

    p_quiet_switch_r7: assert property (@(posedge clk) disable iff (rst)
        (drv_src != $past(drv_src)) |-> !clk_out);

endmodule

bind clk_failover clk_failover_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .prim_sel (prim_sel),
    .man_ovr  (man_ovr),
    .alarm_clr(alarm_clr),
    .bad      ({bad_b, bad_a}),
    .cur_sel  (cur_sel),
    .clk_out  (clk_out),
    .drv_src  (drv_src)
);

// File: tb/clk_failover_test.sv
module clk_failover_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_a = 1'b0;
    logic ref_b = 1'b0;
    logic en_a = 1'b1;
    logic en_b = 1'b1;
    logic prim_sel = 1'b0;
    logic man_ovr = 1'b0;
    logic alarm_clr = 1'b0;
    logic cur_sel, bad_a, bad_b, both_bad, clk_out;

    int tests = 0;
    int fails = 0;
    int hi_run = 0;
    int runts = 0;
    int rises = 0;
    logic prev_out = 1'b0;

    clk_failover uut (
        .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b),
        .prim_sel(prim_sel), .man_ovr(man_ovr), .alarm_clr(alarm_clr),
        .cur_sel(cur_sel), .bad_a(bad_a), .bad_b(bad_b),
        .both_bad(both_bad), .clk_out(clk_out)
    );

    always #4 clk = ~clk;                  // 125 MHz
    always #32 if (en_a) ref_a = ~ref_a;   // half period 4 system cycles
    always #40 if (en_b) ref_b = ~ref_b;   // half period 5 system cycles

    // clk_out pulse monitor (R7, R10)
    always @(negedge clk) begin
        if (clk_out) hi_run = hi_run + 1;
        else begin
            if (hi_run != 0 && hi_run < 3) runts = runts + 1;
            hi_run = 0;
        end
        if (clk_out && !prev_out) rises = rises + 1;
        prev_out = clk_out;
    end

    typedef struct packed {
        logic       ovr;
        logic       ps;
        logic       ea;
        logic       eb;
        logic       clr;
        logic [7:0] cyc;
        logic       sel;
        logic [1:0] bad;   // {bad_b, bad_a}
        logic       both;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'd40,1'b0,2'b00,1'b0,4'd2},  // R2 healthy, no flag
        '{1'b0,1'b1,1'b1,1'b1,1'b0,8'd40,1'b1,2'b00,1'b0,4'd9},  // R9 select B
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'd40,1'b0,2'b00,1'b0,4'd9},  // R9 back to A
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'd40,1'b1,2'b01,1'b0,4'd4},  // R4 A stops
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'd40,1'b1,2'b01,1'b0,4'd3},  // R3 stays latched
        '{1'b0,1'b0,1'b1,1'b1,1'b1,8'd30,1'b1,2'b00,1'b0,4'd8},  // R8 clear, no return
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'd40,1'b1,2'b00,1'b0,4'd8},  // R8 still on B
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'd40,1'b0,2'b10,1'b0,4'd4},  // R4 B stops
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'd40,1'b0,2'b11,1'b1,4'd6},  // R6 both stop
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'd40,1'b0,2'b11,1'b1,4'd6},  // R6 hold
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'd30,1'b0,2'b11,1'b1,4'd3},  // R3 recovered, latched
        '{1'b0,1'b0,1'b1,1'b1,1'b1,8'd30,1'b0,2'b00,1'b0,4'd3},  // R3 cleared
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'd40,1'b0,2'b00,1'b0,4'd3},  // R3 stays clear
        '{1'b1,1'b1,1'b1,1'b1,1'b0,8'd40,1'b1,2'b00,1'b0,4'd5},  // R5 override to B
        '{1'b1,1'b1,1'b1,1'b0,1'b0,8'd40,1'b1,2'b10,1'b0,4'd5},  // R5 no failover
        '{1'b1,1'b0,1'b1,1'b0,1'b0,8'd40,1'b0,2'b10,1'b0,4'd5},  // R5 to A
        '{1'b1,1'b1,1'b1,1'b0,1'b0,8'd40,1'b1,2'b10,1'b0,4'd5},  // R5 onto bad B
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'd40,1'b0,2'b10,1'b0,4'd4},  // R4 auto resumes
        '{1'b0,1'b1,1'b1,1'b1,1'b1,8'd30,1'b0,2'b00,1'b0,4'd8}   // R8 clear, stay A
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset state with prim_sel = 1
        prim_sel = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 cur_sel", int'(cur_sel), 1);
        chk("R1 flags", int'({both_bad, bad_b, bad_a}), 0);
        chk("R1 clk_out", int'(clk_out), 0);

        // R10 clk_out follows B (period 10 cycles)
        rst = 1'b0;
        repeat (20) @(negedge clk);
        rises = 0;
        repeat (200) @(negedge clk);
        chk_rng("R10 B rate", rises, 19, 21);

        // R9/R10 switch to A (period 8 cycles)
        prim_sel = 1'b0;
        repeat (40) @(negedge clk);
        chk("R9 cur_sel", int'(cur_sel), 0);
        rises = 0;
        repeat (200) @(negedge clk);
        chk_rng("R10 A rate", rises, 24, 26);

        // R2 boundary on the unselected reference
        en_b = 1'b0;
        repeat (10) @(negedge clk);
        chk("R2 early", int'(bad_b), 0);
        repeat (15) @(negedge clk);
        chk("R2 late", int'(bad_b), 1);
        chk("R2 other", int'(bad_a), 0);
        en_b = 1'b1;
        repeat (20) @(negedge clk);

        // fresh start for the vector walk
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            man_ovr   = VEC[i].ovr;
            prim_sel  = VEC[i].ps;
            en_a      = VEC[i].ea;
            en_b      = VEC[i].eb;
            alarm_clr = VEC[i].clr;
            repeat (int'(VEC[i].cyc)) @(negedge clk);
            chk($sformatf("R%0d step %0d sel", VEC[i].req, i), int'(cur_sel), int'(VEC[i].sel));
            chk($sformatf("R%0d step %0d flags", VEC[i].req, i), int'({bad_b, bad_a}), int'(VEC[i].bad));
            chk($sformatf("R%0d step %0d both", VEC[i].req, i), int'(both_bad), int'(VEC[i].both));
        end
        alarm_clr = 1'b0;
        repeat (20) @(negedge clk);

        // R7 no short high pulses over the whole run
        chk("R7 runt pulses", runts, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule